// File: doc/BRIEF.md
# UART Transmit Queue and Data-Request Logic

This block is the transmit side of a serial port, covering everything from the software write strobe up to the shift register. It stores outgoing characters in a 64-entry first-in first-out queue. When queue mode is off, the same storage is limited to a single holding slot. It shows the oldest character to the shift logic. When the shift logic takes that character, it acknowledges with a load strobe. When the last bit has left the line, it reports this with a shift-complete strobe. Serial bit timing lies outside this block.

From the queue fill level and the shift-register occupancy, the block produces two status bits. The data request tells software or a DMA engine that there is room for more characters. The transmitter-empty bit reports that nothing is left to send. The data-request threshold is chosen at run time: either half full or completely empty. In single-slot mode, the data request follows the hand-over events instead of a fill level. The data request is gated into an interrupt line and a DMA request line.

Top module: `uart_tx_req`

## Requirements
- R1: The queue holds at most 64 characters. A write while it is full is discarded, unless a load into the shift register happens in the same cycle.
- R2: In queue mode with `thr_empty_i` = 0, `data_req_o` is 1 in the cycle after any update that leaves 32 or fewer characters queued, and 0 when more than 32 are queued.
- R3: In queue mode with `thr_empty_i` = 1, `data_req_o` is 1 only while the queue is empty.
- R4: A `fifo_rst_i` pulse empties the queue within one cycle and drives `data_req_o` to 1. Writes and loads in that same cycle are ignored. A character already in the shift register stays there: `tx_empty_o` remains 0 until `sr_done_i`.
- R5: In single-slot mode (`fifo_en_i` = 0), storage is one character. An accepted write clears `data_req_o`. A load that moves the held character into the shift register without an accepted write in the same cycle sets `data_req_o`. A write while the slot is occupied and no load happens is discarded and leaves `data_req_o` unchanged.
- R6: `tx_empty_o` is 1 only when no character is stored and the shift register is empty. A load marks the shift register occupied until `sr_done_i`. A load and a completion in the same cycle leave it occupied.
- R7: `irq_o` equals `data_req_o` AND `irq_en_i`. `dma_req_o` equals `data_req_o` AND `dma_en_i` AND `fifo_en_i`.
- R8: After reset, `data_req_o` = 1, `tx_empty_o` = 1 and `sr_avail_o` = 0.
- R9: A write and a load in the same cycle leave the stored count unchanged. This holds also when the queue is full.
- R10: Characters reach `sr_data_o` in the order they were accepted. `sr_data_o` is the oldest stored character whenever `sr_avail_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = 64-entry queue mode, 0 = single-slot mode |
| thr_empty_i | input | 1 | Request threshold: 0 = half or less, 1 = empty |
| fifo_rst_i | input | 1 | Queue flush strobe |
| wr_i | input | 1 | Character write strobe |
| wr_data_i | input | 8 | Character written |
| sr_ld_i | input | 1 | Shift register takes the head character |
| sr_done_i | input | 1 | Shift register finished sending |
| irq_en_i | input | 1 | Data-request interrupt enable |
| dma_en_i | input | 1 | DMA request enable |
| sr_data_o | output | 8 | Oldest stored character |
| sr_avail_o | output | 1 | A character is available to load |
| data_req_o | output | 1 | Transmit data request |
| tx_empty_o | output | 1 | Transmitter empty |
| irq_o | output | 1 | Data-request interrupt |
| dma_req_o | output | 1 | DMA request |

## Verification
The bench fills the queue one character at a time past the half-way mark and past capacity, then drains it. This separates an off-by-one threshold compare from a wrong overflow rule. Writes and loads are issued in the same cycle both at mid level and at full level, which separates a count that is kept consistent from one that drifts. A flush while the shift register is busy tells apart a flush that also clears shift-register occupancy. Single-slot sequences with discarded and overlapping writes tell apart event-driven request behaviour from level-driven behaviour. The scoreboard catches any character that is lost, reordered or wrongly kept.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned TX_DEPTH = 64;
  localparam int unsigned TX_DW    = 8;

  typedef enum logic {
    THR_HALF  = 1'b0,
    THR_EMPTY = 1'b1
  } thr_sel_e;
endpackage

// File: rtl/uart_tx_store.sv
module uart_tx_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  output logic [DW-1:0] head_o,
  output logic          avail_o,
  output logic          push_o,
  output logic          pop_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q, cap;

  assign cap     = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign avail_o = (cnt_q != '0);
  assign pop_o   = rd_i && avail_o && !flush_i;
  // a pop frees a slot in the same cycle
  assign push_o  = wr_i && !flush_i && ((cnt_q < cap) || pop_o);
  assign head_o  = mem_q[rd_ptr_q];

  always_comb begin
    if (flush_i) cnt_nxt_o = '0;
    else         cnt_nxt_o = cnt_q + CW'(push_o) - CW'(pop_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_nxt_o;
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (push_o) wr_ptr_q <= wr_ptr_q + AW'(1);
        if (pop_o)  rd_ptr_q <= rd_ptr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_o) mem_q[wr_ptr_q] <= wr_data_i;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/uart_tx_req_gen.sv
module uart_tx_req_gen
  import uart_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH) + 1,
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  thr_sel_e      thr_sel_i,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [CW-1:0] cnt_nxt_i,
  output logic          req_o
);
  logic req_q, req_d;

  always_comb begin
    if (fifo_en_i) begin
      unique case (thr_sel_i)
        THR_EMPTY: req_d = (cnt_nxt_i == '0);
        default:   req_d = (cnt_nxt_i <= CW'(HALF));
      endcase
    end else if (flush_i) begin
      req_d = 1'b1;
    end else if (push_i) begin
      req_d = 1'b0;
    end else if (pop_i) begin
      req_d = 1'b1;
    end else begin
      req_d = req_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b1;
    else         req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/uart_tx_sr_track.sv
module uart_tx_sr_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (load_i) busy_q <= 1'b1;
    else if (done_i) busy_q <= 1'b0;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/uart_tx_req.sv
module uart_tx_req
  import uart_tx_pkg::*;
#(
  parameter int unsigned DEPTH = TX_DEPTH,
  parameter int unsigned DW    = TX_DW,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          thr_empty_i,
  input  logic          fifo_rst_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          sr_ld_i,
  input  logic          sr_done_i,
  input  logic          irq_en_i,
  input  logic          dma_en_i,
  output logic [DW-1:0] sr_data_o,
  output logic          sr_avail_o,
  output logic          data_req_o,
  output logic          tx_empty_o,
  output logic          irq_o,
  output logic          dma_req_o
);
  logic          push, pop, sr_busy;
  logic [CW-1:0] cnt, cnt_nxt;
  thr_sel_e      thr_sel;

  assign thr_sel = thr_sel_e'(thr_empty_i);

  uart_tx_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .flush_i   (fifo_rst_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .rd_i      (sr_ld_i),
    .head_o    (sr_data_o),
    .avail_o   (sr_avail_o),
    .push_o    (push),
    .pop_o     (pop),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  uart_tx_req_gen #(.DEPTH(DEPTH)) i_req_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .thr_sel_i (thr_sel),
    .flush_i   (fifo_rst_i),
    .push_i    (push),
    .pop_i     (pop),
    .cnt_nxt_i (cnt_nxt),
    .req_o     (data_req_o)
  );

  uart_tx_sr_track i_sr_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pop),
    .done_i (sr_done_i),
    .busy_o (sr_busy)
  );

  assign tx_empty_o = !sr_avail_o && !sr_busy;
  assign irq_o      = data_req_o && irq_en_i;
  assign dma_req_o  = data_req_o && dma_en_i && fifo_en_i;
endmodule

// File: rtl/uart_tx_req_chk.sv
module uart_tx_req_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          thr_empty_i,
  input logic          fifo_rst_i,
  input logic          wr_i,
  input logic          sr_ld_i,
  input logic          sr_done_i,
  input logic          sr_avail_o,
  input logic          data_req_o,
  input logic          tx_empty_o,
  input logic          irq_o,
  input logic          dma_req_o,
  input logic [CW-1:0] cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH)); // R1
  AST_HALF_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && !thr_empty_i && $stable(fifo_en_i) && $stable(thr_empty_i))
    |-> (data_req_o == (cnt <= CW'(DEPTH/2)))); // R2
  AST_EMPTY_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && thr_empty_i && $stable(fifo_en_i) && $stable(thr_empty_i))
    |-> (data_req_o == (cnt == '0))); // R3
  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_i |=> (data_req_o && !sr_avail_o)); // R4
  AST_FLUSH_KEEPS_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rst_i && !tx_empty_o && !sr_avail_o && !sr_done_i) |=> !tx_empty_o); // R4
  AST_SLOT_WR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && wr_i && !fifo_rst_i && !sr_avail_o) |=> !data_req_o); // R5
  AST_SLOT_LD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && sr_ld_i && sr_avail_o && !wr_i && !fifo_rst_i) |=> data_req_o); // R5
  AST_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_ld_i && sr_avail_o && !fifo_rst_i) |=> !tx_empty_o); // R6
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> data_req_o); // R7
  AST_DMA_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (data_req_o && fifo_en_i)); // R7
  AST_WR_LD_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sr_ld_i && sr_avail_o && !fifo_rst_i) |=> $stable(cnt)); // R9
endmodule

bind uart_tx_req uart_tx_req_chk #(.DEPTH(DEPTH)) i_uart_tx_req_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_en_i   (fifo_en_i),
  .thr_empty_i (thr_empty_i),
  .fifo_rst_i  (fifo_rst_i),
  .wr_i        (wr_i),
  .sr_ld_i     (sr_ld_i),
  .sr_done_i   (sr_done_i),
  .sr_avail_o  (sr_avail_o),
  .data_req_o  (data_req_o),
  .tx_empty_o  (tx_empty_o),
  .irq_o       (irq_o),
  .dma_req_o   (dma_req_o),
  .cnt         (cnt)
);

// File: tb/test_uart_tx_req.sv
`timescale 1ns/1ps
module test_uart_tx_req;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_en_i = 1'b1, thr_empty_i = 1'b0, fifo_rst_i = 1'b0;
  logic       wr_i = 1'b0, sr_ld_i = 1'b0, sr_done_i = 1'b0;
  logic       irq_en_i = 1'b0, dma_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] sr_data_o;
  logic       sr_avail_o, data_req_o, tx_empty_o, irq_o, dma_req_o;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0;
  bit m_busy = 0, m_req = 1, finished = 0;
  logic [7:0] exp_q [$];

  always #2 clk_i = ~clk_i;

  uart_tx_req i_uart_tx_req (.*);

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    check(tag, "data_req", data_req_o, m_req);
    check(tag, "tx_empty", tx_empty_o, (m_cnt == 0) && !m_busy);
    check(tag, "sr_avail", sr_avail_o, m_cnt != 0);
    check(tag, "irq", irq_o, m_req && irq_en_i);
    check(tag, "dma", dma_req_o, m_req && dma_en_i && fifo_en_i);
  endtask

  // driver: applies one cycle of stimulus, updates the model and the scoreboard queue
  task automatic step(bit wr, logic [7:0] d, bit ld, bit done, bit rst, string tag);
    bit pop, acc;
    int cap, nxt;
    wr_i = wr; wr_data_i = d; sr_ld_i = ld; sr_done_i = done; fifo_rst_i = rst;
    cap = fifo_en_i ? 64 : 1;
    pop = ld && (m_cnt > 0) && !rst;
    acc = wr && !rst && ((m_cnt < cap) || pop);
    nxt = rst ? 0 : m_cnt + int'(acc) - int'(pop);
    @(posedge clk_i);
    #1;
    if (fifo_en_i) m_req = thr_empty_i ? (nxt == 0) : (nxt <= 32);
    else if (rst)  m_req = 1;
    else if (acc)  m_req = 0;
    else if (pop)  m_req = 1;
    if (pop) m_busy = 1;
    else if (done) m_busy = 0;
    m_cnt = nxt;
    if (rst) exp_q.delete();
    if (acc) exp_q.push_back(d);
    wr_i = 0; sr_ld_i = 0; sr_done_i = 0; fifo_rst_i = 0;
    check_outs(tag);
  endtask

  // monitor: compares each character handed to the shift register against the scoreboard (R10)
  always @(negedge clk_i) begin
    if (rst_ni && sr_ld_i && sr_avail_o && !fifo_rst_i) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10 sr_data: actual %0d expected none", sr_data_o);
      end else begin
        check("R10", "sr_data", sr_data_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #7;
    check("R8", "data_req", data_req_o, 1);
    check("R8", "tx_empty", tx_empty_o, 1);
    check("R8", "sr_avail", sr_avail_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check_outs("R8");

    // R2 / R1: fill past half and past capacity, then drain
    for (int i = 0; i < 66; i++) step(1, 8'(i + 1), 0, 0, 0, (i < 64) ? "R2" : "R1");
    for (int i = 0; i < 64; i++) step(0, 0, 1, 1, 0, "R2");
    step(0, 0, 0, 1, 0, "R6");

    // R3: empty threshold
    thr_empty_i = 1'b1;
    for (int i = 0; i < 3; i++) step(1, 8'(8'hA0 + i), 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, "R3");
    step(0, 0, 0, 1, 0, "R6");

    // R9: simultaneous write and load at mid level and at full level
    thr_empty_i = 1'b0;
    for (int i = 0; i < 33; i++) step(1, 8'(8'h40 + i), 0, 0, 0, "R2");
    step(1, 8'h90, 1, 0, 0, "R9");
    for (int i = 0; i < 32; i++) step(1, 8'(8'h60 + i), 0, 0, 0, "R1");
    step(1, 8'hEE, 0, 0, 0, "R1");
    step(1, 8'h91, 1, 1, 0, "R9");
    for (int i = 0; i < 40; i++) step(0, 0, 1, 1, 0, "R9");

    // R4: flush with a character still in the shift register
    step(1, 8'h55, 0, 0, 1, "R4");
    step(0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 0, "R4");

    // R5: single-slot mode
    fifo_en_i = 1'b0;
    step(0, 0, 0, 0, 0, "R5");
    step(1, 8'h11, 0, 0, 0, "R5");
    step(1, 8'h22, 0, 0, 0, "R5");
    step(1, 8'h33, 1, 0, 0, "R5");
    step(0, 0, 1, 1, 0, "R5");
    step(0, 0, 0, 1, 0, "R6");
    step(1, 8'h44, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 1, "R4");

    // R7: interrupt and DMA gating
    irq_en_i = 1'b1; dma_en_i = 1'b1;
    step(0, 0, 0, 0, 0, "R7");
    fifo_en_i = 1'b1;
    step(0, 0, 0, 0, 0, "R7");
    thr_empty_i = 1'b1;
    step(1, 8'h77, 0, 0, 0, "R7");
    irq_en_i = 1'b0;
    step(0, 0, 1, 0, 0, "R7");
    step(0, 0, 0, 1, 0, "R6");
    check("R10", "scoreboard_left", exp_q.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule